// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Collision Behaviour

This block is a single-clock RAM with one write port and one read port. Each port has its own enable and address, and the write port also has a data input. When both ports use the same address in the same cycle, the read port can return one of three things. A build parameter chooses which: the word being written, the word the location held before the write, or an undefined word.

The read path always goes through one register that sits next to the storage. An optional second register on the output adds one cycle of latency. In exchange, the clock-to-out path of the RAM is cut off from the logic that follows. Forwarding the written word is only allowed when that second register is present. Elaboration stops with an error if forwarding is asked for with a combinational output. Two undefined-result settings exist and both are accepted: a plain one and a timing-constrained one. In this model they behave the same.

Top module: `rdw_dpram`

## Requirements
- R1: A synchronous reset drives `rd_data` to zero on the next clock edge. It leaves the stored words untouched, so a read issued after reset still returns data written before it.
- R2: A read to an address not being written in the same cycle returns the stored word. It appears 1 cycle after the read edge when `OUT_REG` = 0, and 2 cycles after when `OUT_REG` = 1.
- R3: While no read is issued, `rd_data` keeps the result of the last read.
- R4: With `wr_en` low, the values on `wr_addr` and `wr_data` leave the memory unchanged.
- R5: With `RDW_MODE` = NEW (encoding 0), a read that collides with a write returns the word being written.
- R6: With `RDW_MODE` = OLD (encoding 1), a colliding read returns the word held before the write. A later read of that address returns the new word.
- R7: With `RDW_MODE` = DONT_CARE (2) or CONSTRAINED_DONT_CARE (3), the colliding result is undefined. The reads that follow, whether colliding or not, return correct data.
- R8: A collision exists only when both enables are high and the two addresses are equal. A write to another address, or a write to the same address with `rd_en` low, does not disturb the read result.
- R9: Every location from address 0 to the top address holds its own word. Writes to the lowest and highest locations do not alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read pipeline |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read result |

## Verification
The bench builds five copies side by side from the same stimulus:
- NEW with the output register;
- OLD without it;
- OLD with it;
- DONT_CARE with it;
- CONSTRAINED_DONT_CARE without it.

Both latencies are therefore covered in OLD mode. Forwarding is covered at its one legal latency, and both undefined-result settings are tested at different latencies. This makes it possible to see how one collision is resolved by each mode and each latency at once. For the undefined modes, the collision result is skipped and only the reads that follow are compared.

// File: rtl/rdw_pkg.sv
package rdw_pkg;
  typedef enum logic [1:0] {
    RDW_NEW            = 2'd0,
    RDW_OLD            = 2'd1,
    RDW_DONT_CARE      = 2'd2,
    RDW_CONSTRAINED_DC = 2'd3
  } rdw_mode_e;
endpackage

// File: rtl/rdw_store.sv
module rdw_store #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] raw_q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // read register next to the array: returns the pre-write word on collision
  always_ff @(posedge clk) begin
    if (rst)        raw_q <= '0;
    else if (rd_en) raw_q <= mem[rd_addr];
  end

  // R3
  raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!rd_en && !$past(rst)) |=> $stable(raw_q));
endmodule

// File: rtl/rdw_collide.sv
module rdw_collide #(
  parameter int                DATA_W   = 16,
  parameter int                ADDR_W   = 5,
  parameter rdw_pkg::rdw_mode_e RDW_MODE = rdw_pkg::RDW_OLD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] raw_q,
  output logic [DATA_W-1:0] sel_data,
  output logic              sel_vld
);
  logic              hit;
  logic              hit_q;
  logic [DATA_W-1:0] wd_q;

  assign hit = wr_en && rd_en && (wr_addr == rd_addr);

  // collision flag and bypass word follow the read register: held when idle
  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q   <= 1'b0;
      wd_q    <= '0;
      sel_vld <= 1'b0;
    end else begin
      sel_vld <= rd_en;
      if (rd_en) begin
        hit_q <= hit;
        wd_q  <= wr_data;
      end
    end
  end

  generate
    if (RDW_MODE == rdw_pkg::RDW_NEW) begin : g_new
      assign sel_data = hit_q ? wd_q : raw_q;
      // R5
      new_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        hit |=> sel_data == $past(wr_data));
    end else if (RDW_MODE == rdw_pkg::RDW_OLD) begin : g_old
      assign sel_data = raw_q;
    end else begin : g_undef
      assign sel_data = hit_q ? {DATA_W{1'bx}} : raw_q;
    end
  endgenerate

  // R8
  no_false_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !(wr_en && wr_addr == rd_addr)) |=> sel_data == raw_q);
endmodule

// File: rtl/rdw_outstage.sv
module rdw_outstage #(
  parameter int DATA_W  = 16,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_vld,
  output logic [DATA_W-1:0] rd_data
);
  generate
    if (OUT_REG) begin : g_reg
      logic [DATA_W-1:0] out_q;
      always_ff @(posedge clk) begin
        if (rst)         out_q <= '0;
        else if (in_vld) out_q <= in_data;
      end
      assign rd_data = out_q;

      // R3
      out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_vld && !$past(rst)) |=> $stable(rd_data));
    end else begin : g_comb
      assign rd_data = in_data;
    end
  endgenerate
endmodule

// File: rtl/rdw_dpram.sv
module rdw_dpram #(
  parameter int                 DATA_W   = 16,
  parameter int                 ADDR_W   = 5,
  parameter bit                 OUT_REG  = 1'b1,
  parameter rdw_pkg::rdw_mode_e RDW_MODE = rdw_pkg::RDW_OLD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  // forwarding needs the output register to absorb the bypass mux
  generate
    if (RDW_MODE == rdw_pkg::RDW_NEW && !OUT_REG) begin : g_illegal
      $error("rdw_dpram: NEW collision mode requires OUT_REG = 1");
    end
  endgenerate

  logic [DATA_W-1:0] raw_q;
  logic [DATA_W-1:0] sel_data;
  logic              sel_vld;

  rdw_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .raw_q(raw_q)
  );

  rdw_collide #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RDW_MODE(RDW_MODE)) u_coll (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr),
    .raw_q(raw_q),
    .sel_data(sel_data), .sel_vld(sel_vld)
  );

  rdw_outstage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
    .clk(clk), .rst(rst),
    .in_data(sel_data), .in_vld(sel_vld),
    .rd_data(rd_data)
  );

  // R1
  rst_zero_chk: assert property (@(posedge clk)
    rst |=> rd_data == '0);
endmodule

// File: tb/sim_rdw_dpram.sv
`timescale 1ns/1ps
module sim_rdw_dpram;
  localparam int DW = 16;
  localparam int AW = 5;
  localparam int NV = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0, re = 1'b0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] q0, q1, q2, q3, q4;

  always #4 clk = ~clk;

  rdw_dpram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b1), .RDW_MODE(rdw_pkg::RDW_NEW)) u0 (
    .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_en(re), .rd_addr(ra), .rd_data(q0));
  rdw_dpram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b0), .RDW_MODE(rdw_pkg::RDW_OLD)) u1 (
    .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_en(re), .rd_addr(ra), .rd_data(q1));
  rdw_dpram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b1), .RDW_MODE(rdw_pkg::RDW_OLD)) u2 (
    .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_en(re), .rd_addr(ra), .rd_data(q2));
  rdw_dpram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b1), .RDW_MODE(rdw_pkg::RDW_DONT_CARE)) u3 (
    .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_en(re), .rd_addr(ra), .rd_data(q3));
  rdw_dpram #(.DATA_W(DW), .ADDR_W(AW), .OUT_REG(1'b0), .RDW_MODE(rdw_pkg::RDW_CONSTRAINED_DC)) u4 (
    .clk(clk), .rst(rst), .wr_en(we), .wr_addr(wa), .wr_data(wd),
    .rd_en(re), .rd_addr(ra), .rd_data(q4));

  // {tag, wr_en, wr_addr, wr_data, rd_en, rd_addr}
  localparam logic [31:0] VEC [NV] = '{
    {4'd9, 1'b1, 5'd3,  16'h1111, 1'b0, 5'd0 },  // R9 write only
    {4'd9, 1'b1, 5'd7,  16'h2222, 1'b0, 5'd0 },  // R9
    {4'd2, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd3 },  // R2 plain read
    {4'd2, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd7 },  // R2
    {4'd3, 1'b0, 5'd0,  16'h0000, 1'b0, 5'd0 },  // R3 idle, hold
    {4'd4, 1'b0, 5'd3,  16'hDEAD, 1'b0, 5'd3 },  // R4 disabled write
    {4'd4, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd3 },  // R4 still 1111
    {4'd6, 1'b1, 5'd3,  16'h3333, 1'b1, 5'd3 },  // R5 R6 R7 collision
    {4'd6, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd3 },  // R6 new word later
    {4'd8, 1'b1, 5'd7,  16'h4444, 1'b1, 5'd3 },  // R8 other address
    {4'd8, 1'b1, 5'd7,  16'h5555, 1'b0, 5'd7 },  // R8 same addr, rd_en low
    {4'd8, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd7 },  // R8
    {4'd9, 1'b1, 5'd31, 16'hFFFF, 1'b0, 5'd0 },  // R9 top address
    {4'd9, 1'b1, 5'd0,  16'h0001, 1'b1, 5'd31},  // R9 bottom while reading top
    {4'd9, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd0 },  // R9
    {4'd5, 1'b1, 5'd31, 16'h7777, 1'b1, 5'd31},  // R5 collision at top
    {4'd5, 1'b1, 5'd31, 16'h8888, 1'b1, 5'd31},  // R5 back-to-back
    {4'd7, 1'b0, 5'd0,  16'h0000, 1'b1, 5'd31},  // R7 recovery read
    {4'd3, 1'b0, 5'd0,  16'h0000, 1'b0, 5'd0 }   // R3 hold
  };

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // bench model state
  logic [DW-1:0] shadow [1<<AW];
  logic [DW-1:0] s1_old, s1_new, o2_old, o2_new;
  bit            s1_def, o2_def, o_en;

  task automatic chk(input int tag, input string who, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s act=%h exp=%h", tag, who, act, exp);
    end
  endtask

  task automatic model_reset();
    s1_old = '0; s1_new = '0; o2_old = '0; o2_new = '0;
    s1_def = 1'b1; o2_def = 1'b1; o_en = 1'b0;
  endtask

  task automatic check_all(input int tag);
    chk(tag, "u0 new/reg",   q0, o2_new);
    chk(tag, "u1 old/comb",  q1, s1_old);
    chk(tag, "u2 old/reg",   q2, o2_old);
    if (o2_def) chk(tag, "u3 dc/reg",   q3, o2_old);
    if (s1_def) chk(tag, "u4 cdc/comb", q4, s1_old);
  endtask

  task automatic step(input int tag, input logic w, input logic [AW-1:0] a,
                      input logic [DW-1:0] d, input logic r, input logic [AW-1:0] b);
    logic [DW-1:0] oldv, newv;
    bit coll;
    we = w; wa = a; wd = d; re = r; ra = b;
    oldv = shadow[b];
    coll = w && r && (a == b);
    newv = coll ? d : oldv;
    @(posedge clk);
    @(negedge clk);
    if (o_en) begin o2_old = s1_old; o2_new = s1_new; o2_def = s1_def; end
    if (r) begin s1_old = oldv; s1_new = newv; s1_def = !coll; end
    o_en = r;
    if (w) shadow[a] = d;
    check_all(tag);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) shadow[i] = '0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check_all(1);
    rst = 1'b0;
    for (int i = 0; i < NV; i++)
      step(int'(VEC[i][31:28]), VEC[i][27], VEC[i][26:22], VEC[i][21:6],
           VEC[i][5], VEC[i][4:0]);
    // R1 mid-run reset while a read is requested: outputs clear, memory kept
    rst = 1'b1; re = 1'b1; ra = 5'd7; we = 1'b0;
    @(posedge clk); @(negedge clk);
    model_reset();
    check_all(1);
    rst = 1'b0;
    step(1, 1'b0, 5'd0, 16'h0, 1'b1, 5'd7);
    step(1, 1'b0, 5'd0, 16'h0, 1'b0, 5'd0);
    chk(1, "u0 kept word after reset", q0, 16'h5555);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule